// File: doc/BRIEF.md
# Parallel Port Floppy Pin-Sharing Controller

This block lets the signals of an on-chip floppy disk controller borrow the pins of a parallel printer port. A two-bit mode field picks one of three settings: the ordinary printer port, a one-drive sharing mode that places only drive 1 on the printer pins, or a two-drive sharing mode that places both drive 0 and drive 1 there. The block also owns the printer port's data and control registers and the read path for the data, status and control registers.

While a sharing mode is set, the printer pins carry floppy signals through a fixed pin table whenever the floppy controller selects a drive routed to them. During those cycles the ten dedicated floppy output pins are released to high impedance. When no shared drive is selected, the dedicated pins stay driven and the shared pins rest at their inactive (high) levels. Reads of the printer registers in a sharing mode report a printer with no cable attached. Only a write of the normal setting brings the printer back.

Top module: `ppfd_mux`

## Requirements
- R1: After reset the mode is normal, all ten dedicated floppy enables are 1, the data pins read 0x00, the control pins read 0x0, and a data register read returns 0x00.
- R2: In normal mode the data pins carry the data register, the control pins carry the control register bits 3:0, and the dedicated enables are all 1. Reads at address 0 return the data register. Reads at address 1 return {statusPins[4:0], 3'b000}. Reads at address 2 return {4'b0000, control[3:0]}.
- R3: A mode write with code 00 selects normal, 01 selects one-drive, and 10 selects two-drive. The new mode takes effect from the clock edge that samples the write. Code 11 is ignored and leaves the mode unchanged.
- R4: In a sharing mode a data register read returns the last value written to the data register, including writes made while sharing.
- R5: In a sharing mode a control register read returns 0x04: strobe=0, auto-feed=0, init-not=1, select-in=0.
- R6: In a sharing mode a status register read returns 0x48: busy-not=0, ack-not=1, paper-end=0, select=0, error-not=1 in bits 7..3.
- R7: In two-drive mode, while either drive-select (active low) is 0, all dedicated enables are 0 and the shared pins carry the pin table.
- R8: In one-drive mode, only drive-select 1 low routes to the shared pins. With drive-select 1 high, the dedicated enables stay 1, the data pins read 0xFF and the control pins read 0xF.
- R9: Pin table while routed, data bits 7..0: write gate, write data, step, direction, motor 1, motor 0, drive-select 1, drive-select 0. Control bits 3..0: 1, 1, density select, head select. In one-drive mode the motor 0 and drive-select 0 positions are forced to 1.
- R10: The floppy input vector equals the five status pins while the shared pins are routed, and the dedicated floppy inputs otherwise.
- R11: Printer register writes made while sharing do not reach the pins. After a write back to normal, the pins show the stored data and control values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode field write strobe |
| modeWrData | input | 2 | Mode code (00 normal, 01 one-drive, 10 two-drive) |
| regWrEn | input | 1 | Printer register write strobe |
| regAddr | input | 2 | Register select: 0 data, 1 status, 2 control |
| regWrData | input | 8 | Printer register write data |
| regRdData | output | 8 | Printer register read data |
| fdcDsN | input | 2 | Drive selects from the floppy controller, active low |
| fdcMtrN | input | 2 | Motor enables, active low |
| fdcDirN | input | 1 | Step direction |
| fdcStepN | input | 1 | Step pulse |
| fdcWdataN | input | 1 | Write data |
| fdcWgateN | input | 1 | Write gate |
| fdcHdselN | input | 1 | Head select |
| fdcDensel | input | 1 | Density select |
| dedIn | input | 5 | Floppy inputs from the dedicated pins |
| fdcIn | output | 5 | Floppy inputs delivered to the floppy controller |
| statusPins | input | 5 | Printer status pins (busy-not, ack-not, paper-end, select, error-not) |
| padData | output | 8 | Printer data pin outputs |
| padCtrl | output | 4 | Printer control pin outputs |
| dedOe | output | 10 | Output enables of the dedicated floppy pins |

## Verification
On every cycle, the assertions check the fixed no-cable readback values in sharing modes and the release of the dedicated enables in two-drive mode. They also check that the shared pins stay idle in one-drive mode while drive 1 is not selected, that the dedicated pins stay enabled in normal mode, that the reserved mode code is rejected, and that the data register reads back its last write. The pin table bit positions, the choice of the floppy input source, and the return of the stored printer values after leaving a sharing mode are shown only by the bench. The bench sweeps every combination of the ten floppy output signals in each mode and compares the outputs with a table model.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 4;
  localparam int STAT_W  = 5;
  localparam int DED_PIN = 10;
  localparam int ADDR_W  = 2;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_ONE    = 2'b01,
    PM_TWO    = 2'b10
  } ppMode_e;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  localparam logic [DATA_W-1:0] NOCABLE_CTRL = 8'h04;
  localparam logic [DATA_W-1:0] NOCABLE_STAT = 8'h48;

  typedef struct packed {
    logic dataWr;
    logic ctrlWr;
    logic shareMode;
    logic twoDrive;
    logic shareActive;
  } ppStrobe_t;
endpackage

// File: rtl/ppfd_ctrl.sv
module ppfd_ctrl
  import ppfd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [1:0]        modeWrData,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        fdcDsN,
  output ppMode_e           modeQ,
  output ppStrobe_t         stb
);
  logic codeValid;
  assign codeValid = (modeWrData != 2'b11);

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= PM_NORMAL;
    else if (modeWrEn && codeValid) modeQ <= ppMode_e'(modeWrData);
  end

  always_comb begin
    stb.dataWr    = regWrEn && (regAddr == A_DATA);
    stb.ctrlWr    = regWrEn && (regAddr == A_CTRL);
    stb.shareMode = (modeQ != PM_NORMAL);
    stb.twoDrive  = (modeQ == PM_TWO);
    unique case (modeQ)
      PM_TWO:  stb.shareActive = !(&fdcDsN);
      PM_ONE:  stb.shareActive = !fdcDsN[1];
      default: stb.shareActive = 1'b0;
    endcase
  end
endmodule

// File: rtl/ppfd_data.sv
module ppfd_data
  import ppfd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ppStrobe_t          stb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [1:0]         fdcDsN,
  input  logic [1:0]         fdcMtrN,
  input  logic               fdcDirN,
  input  logic               fdcStepN,
  input  logic               fdcWdataN,
  input  logic               fdcWgateN,
  input  logic               fdcHdselN,
  input  logic               fdcDensel,
  input  logic [STAT_W-1:0]  dedIn,
  output logic [STAT_W-1:0]  fdcIn,
  input  logic [STAT_W-1:0]  statusPins,
  output logic [DATA_W-1:0]  padData,
  output logic [CTRL_W-1:0]  padCtrl,
  output logic [DED_PIN-1:0] dedOe
);
  logic [DATA_W-1:0] dataReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] fdData;
  logic [CTRL_W-1:0] fdCtrl;
  logic              keepDrv0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (stb.dataWr) dataReg <= regWrData;
      if (stb.ctrlWr) ctrlReg <= regWrData[CTRL_W-1:0];
    end
  end

  // Drive 0 positions only travel on the shared pins in two-drive mode.
  assign keepDrv0 = stb.twoDrive;

  always_comb begin
    fdData = {fdcWgateN, fdcWdataN, fdcStepN, fdcDirN, fdcMtrN[1],
              keepDrv0 ? fdcMtrN[0] : 1'b1, fdcDsN[1],
              keepDrv0 ? fdcDsN[0] : 1'b1};
    fdCtrl = {2'b11, fdcDensel, fdcHdselN};
  end

  always_comb begin
    if (!stb.shareMode) begin
      padData = dataReg;
      padCtrl = ctrlReg;
    end else if (stb.shareActive) begin
      padData = fdData;
      padCtrl = fdCtrl;
    end else begin
      padData = '1;
      padCtrl = '1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_inSel
      assign fdcIn[gi] = stb.shareActive ? statusPins[gi] : dedIn[gi];
    end
    for (gi = 0; gi < DED_PIN; gi++) begin : g_oe
      assign dedOe[gi] = !stb.shareActive;
    end
  endgenerate

  always_comb begin
    unique case (regAddr)
      A_DATA:  regRdData = dataReg;
      A_STAT:  regRdData = stb.shareMode ? NOCABLE_STAT : {statusPins, 3'b000};
      A_CTRL:  regRdData = stb.shareMode ? NOCABLE_CTRL
                                         : {{(DATA_W-CTRL_W){1'b0}}, ctrlReg};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ppfd_mux.sv
module ppfd_mux
  import ppfd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeWrEn,
  input  logic [1:0]         modeWrData,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [1:0]         fdcDsN,
  input  logic [1:0]         fdcMtrN,
  input  logic               fdcDirN,
  input  logic               fdcStepN,
  input  logic               fdcWdataN,
  input  logic               fdcWgateN,
  input  logic               fdcHdselN,
  input  logic               fdcDensel,
  input  logic [STAT_W-1:0]  dedIn,
  output logic [STAT_W-1:0]  fdcIn,
  input  logic [STAT_W-1:0]  statusPins,
  output logic [DATA_W-1:0]  padData,
  output logic [CTRL_W-1:0]  padCtrl,
  output logic [DED_PIN-1:0] dedOe
);
  ppMode_e   modeQ;
  ppStrobe_t stb;

  ppfd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .regWrEn(regWrEn), .regAddr(regAddr), .fdcDsN(fdcDsN),
    .modeQ(modeQ), .stb(stb)
  );

  ppfd_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .fdcDsN(fdcDsN), .fdcMtrN(fdcMtrN), .fdcDirN(fdcDirN),
    .fdcStepN(fdcStepN), .fdcWdataN(fdcWdataN), .fdcWgateN(fdcWgateN),
    .fdcHdselN(fdcHdselN), .fdcDensel(fdcDensel),
    .dedIn(dedIn), .fdcIn(fdcIn), .statusPins(statusPins),
    .padData(padData), .padCtrl(padCtrl), .dedOe(dedOe)
  );
endmodule

// File: rtl/ppfd_mux_chk.sv
module ppfd_mux_chk
  import ppfd_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input ppMode_e            modeQ,
  input logic               modeWrEn,
  input logic [1:0]         modeWrData,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic [1:0]         fdcDsN,
  input logic [DATA_W-1:0]  padData,
  input logic [CTRL_W-1:0]  padCtrl,
  input logic [DED_PIN-1:0] dedOe
);
  // R3
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeWrData == 2'b11) |=> $stable(modeQ));

  // R5
  nocable_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != PM_NORMAL && regAddr == A_CTRL) |-> regRdData == 8'h04);

  // R6
  nocable_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != PM_NORMAL && regAddr == A_STAT) |-> regRdData == 8'h48);

  // R7
  two_drive_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == PM_TWO && fdcDsN != 2'b11) |-> dedOe == '0);

  // R8
  one_drive_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == PM_ONE && fdcDsN[1]) |-> (dedOe == '1 && padData == 8'hFF && padCtrl == 4'hF));

  // R2
  normal_keeps_ded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == PM_NORMAL) |-> dedOe == '1);

  // R4
  data_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_DATA && !modeWrEn) |=>
      (regAddr != A_DATA || regRdData == $past(regWrData)));
endmodule

bind ppfd_mux ppfd_mux_chk chk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ), .modeWrEn(modeWrEn),
  .modeWrData(modeWrData), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .fdcDsN(fdcDsN),
  .padData(padData), .padCtrl(padCtrl), .dedOe(dedOe)
);

// File: tb/ppfd_mux_test.sv
module ppfd_mux_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWrEn = 1'b0;
  logic [1:0] modeWrData = 2'b00;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [9:0] fv = 10'h3FF;
  logic [4:0] dedIn = 5'h0A;
  logic [4:0] fdcIn;
  logic [4:0] statusPins = 5'h15;
  logic [7:0] padData;
  logic [3:0] padCtrl;
  logic [9:0] dedOe;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ppfd_mux uut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .fdcDsN(fv[1:0]), .fdcMtrN(fv[3:2]), .fdcDirN(fv[4]), .fdcStepN(fv[5]),
    .fdcWdataN(fv[6]), .fdcWgateN(fv[7]), .fdcHdselN(fv[8]), .fdcDensel(fv[9]),
    .dedIn(dedIn), .fdcIn(fdcIn), .statusPins(statusPins),
    .padData(padData), .padCtrl(padCtrl), .dedOe(dedOe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk); modeWrEn = 1'b0;
  endtask

  task automatic regWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, input string req, input logic [7:0] exp);
    regAddr = a; #1;
    check(req, {8'h00, regRdData}, {8'h00, exp});
  endtask

  // Sweep all floppy output patterns for one mode (m: 0 normal, 1 one, 2 two).
  task automatic sweep(input int m, input logic [7:0] dReg, input logic [3:0] cReg);
    for (int v = 0; v < 1024; v++) begin
      logic act;
      logic [7:0] eData;
      logic [3:0] eCtrl;
      fv = v[9:0]; #1;
      act = (m == 2 && fv[1:0] != 2'b11) || (m == 1 && !fv[1]);
      if (m == 0) begin eData = dReg; eCtrl = cReg; end
      else if (!act) begin eData = 8'hFF; eCtrl = 4'hF; end
      else begin
        eData = {fv[7:4], fv[3], (m == 1) ? 1'b1 : fv[2], fv[1], (m == 1) ? 1'b1 : fv[0]};
        eCtrl = {2'b11, fv[9], fv[8]};
      end
      // R7 R8 R9 R2
      check(m == 2 ? "R7/R9 data" : (m == 1 ? "R8/R9 data" : "R2 data"), {8'h00, padData}, {8'h00, eData});
      check(m == 0 ? "R2 ctrl" : "R9 ctrl", {12'h000, padCtrl}, {12'h000, eCtrl});
      check(m == 2 ? "R7 oe" : "R8 oe", {6'h00, dedOe}, {6'h00, act ? 10'h000 : 10'h3FF});
      // R10
      check("R10 fdcIn", {11'h000, fdcIn}, {11'h000, act ? statusPins : dedIn});
      #1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {6'h00, dedOe}, 16'h03FF);
    check("R1 data", {8'h00, padData}, 16'h0000);
    check("R1 ctrl", {12'h000, padCtrl}, 16'h0000);
    readReg(2'd0, "R1 rd", 8'h00);

    // R2 normal mode
    regWr(2'd0, 8'hA5);
    regWr(2'd2, 8'hF9);
    readReg(2'd0, "R2 rd data", 8'hA5);
    readReg(2'd1, "R2 rd stat", {statusPins, 3'b000});
    readReg(2'd2, "R2 rd ctrl", 8'h09);
    sweep(0, 8'hA5, 4'h9);

    // R3 one-drive, then reserved code ignored
    setMode(2'b01);
    fv = 10'h3FF; #1;
    check("R3 one idle", {8'h00, padData}, 16'h00FF);
    setMode(2'b11);
    fv = 10'h3FD; #1;
    check("R3 reserved kept one oe", {6'h00, dedOe}, 16'h0000);
    check("R3 reserved kept one ds0", {15'h0000, padData[0]}, 16'h0001);
    sweep(1, 8'hA5, 4'h9);

    // R4 R5 R6 readback while sharing
    readReg(2'd1, "R6 stat", 8'h48);
    readReg(2'd2, "R5 ctrl", 8'h04);
    readReg(2'd0, "R4 data before", 8'hA5);
    regWr(2'd0, 8'h3C);
    regWr(2'd2, 8'h06);
    readReg(2'd0, "R4 data after", 8'h3C);
    readReg(2'd2, "R5 ctrl after write", 8'h04);
    fv = 10'h3FF; #1;
    check("R11 pins untouched", {4'h0, padCtrl, padData}, 16'h0FFF);

    // two-drive
    setMode(2'b10);
    sweep(2, 8'h3C, 4'h6);
    readReg(2'd1, "R6 stat two", 8'h48);

    // R11 back to normal
    setMode(2'b00);
    fv = 10'h3FC; #1;
    check("R11 data", {8'h00, padData}, 16'h003C);
    check("R11 ctrl", {12'h000, padCtrl}, 16'h0006);
    check("R11 oe", {6'h00, dedOe}, 16'h03FF);
    readReg(2'd2, "R11 rd ctrl", 8'h06);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule